// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block provides a two-byte index/data window on an 8-bit I/O bus that reaches a bank of 256 one-byte configuration registers. A byte write to the even address of the window selects a register by storing its number in an index latch. Reads and writes at the odd address then reach the selected register. A read at either window address returns the register that the latch currently selects. Register contents are combinational at the read port. Writes take effect at the next rising clock edge.

Each data write passes through a fixed protection policy. Large groups of registers cannot be written at all. Two registers only accept one exact key byte and keep their old value for any other byte. All remaining registers store whatever is written.

The window starts disabled after reset. It is switched on or off by a byte written through a separate host-bridge configuration strobe. While the window is off, it neither claims reads nor accepts writes.

Top module: `cfg_index_port`

## Requirements
- R1: Reset loads 0x3C at register 0xE0, 0x03 at 0xE2, 0xFC at 0xE3, 0xDE at 0xE6, 0xFE at 0xE7 and 0xBE at 0xE8. Every other register resets to 0x00. The index latch resets to 0x00 and the window resets to disabled.
- R2: A bridge configuration write (`brg_cfg_we` high) whose offset equals 0x85 sets the window enable to bit 1 of its data byte. Writes at any other offset leave the enable unchanged.
- R3: While the window is disabled, `io_hit` stays 0 and `io_rdata` reads 0xFF. I/O writes change neither the index latch nor any register.
- R4: With the window enabled, a write to address 0x3F0 stores the data byte as the index, effective from the next cycle.
- R5: With the window enabled, a read (`io_rd` high) at 0x3F0 or 0x3F1 raises `io_hit` and returns the register selected by the index in the same cycle. A read at any other address gives `io_hit` = 0 and 0xFF.
- R6: A data write (address 0x3F1) is discarded when the index is in 0x00–0xDF or 0xE9–0xED, or equals 0xE4, 0xE5, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R7: A data write at index 0xE7 is stored only when the byte is 0xFE, and at index 0xE8 only when the byte is 0xBE. Any other byte leaves the register unchanged.
- R8: A data write at any index not covered by R6 or R7 (0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8, 0xFC) stores the byte, and the byte is readable from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O byte address |
| io_rd | input | 1 | Read strobe, one byte |
| io_wr | input | 1 | Write strobe, one byte |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data; 0xFF when the read is not claimed |
| io_hit | output | 1 | High when the window claims the current read |
| brg_cfg_we | input | 1 | Host-bridge configuration write strobe |
| brg_cfg_off | input | 8 | Host-bridge configuration byte offset |
| brg_cfg_wdata | input | 8 | Host-bridge configuration data byte |

## Verification
A wrong index latch appears at the very next read: that read returns the wrong register. The bench reads back after every index or data write, so such an error is seen within one cycle. A filter error that lets a protected write through, or drops a permitted one, shows as a mismatch on the following readback of that register. A stuck or misdecoded enable shows as a wrong `io_hit` or 0xFF pattern on the first read after the bridge write.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

   localparam int REG_W    = 8;
   localparam int IDX_W    = 8;
   localparam int NUM_REGS = 1 << IDX_W;

   typedef logic [REG_W-1:0] reg_byte_t;
   typedef logic [IDX_W-1:0] reg_idx_t;

   // value each register takes at reset
   function automatic reg_byte_t reg_default(input reg_idx_t i);
      case (i)
         8'hE0:   return 8'h3C;
         8'hE2:   return 8'h03;
         8'hE3:   return 8'hFC;
         8'hE6:   return 8'hDE;
         8'hE7:   return 8'hFE;
         8'hE8:   return 8'hBE;
         default: return 8'h00;
      endcase
   endfunction

   // registers that never accept a data write
   function automatic logic is_locked(input reg_idx_t i);
      case (i) inside
         [8'h00:8'hDF], [8'hE9:8'hED], [8'hF9:8'hFB], [8'hFD:8'hFF],
         8'hE4, 8'hE5, 8'hF3, 8'hF5, 8'hF7: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // registers that accept only one key byte
   function automatic logic is_keyed(input reg_idx_t i);
      return (i == 8'hE7) || (i == 8'hE8);
   endfunction

   function automatic reg_byte_t key_value(input reg_idx_t i);
      return (i == 8'hE7) ? 8'hFE : 8'hBE;
   endfunction

endpackage

// File: rtl/cfg_port_enable.sv
module cfg_port_enable #(
   parameter int         OFF_W     = 8,
   parameter int         DAT_W     = 8,
   parameter [OFF_W-1:0] EN_OFFSET = 8'h85,
   parameter int         EN_BIT    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [OFF_W-1:0] cfg_off,
   input  logic [DAT_W-1:0] cfg_wdata,
   output logic             win_en
);

   if (EN_BIT >= DAT_W) begin : g_bad_bit
      $error("cfg_port_enable: EN_BIT outside the data byte");
   end

   logic unused_cfg_bits;
   assign unused_cfg_bits = ^cfg_wdata;

   logic hit_off;
   assign hit_off = cfg_we && (cfg_off == EN_OFFSET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       win_en <= 1'b0;
      else if (hit_off) win_en <= cfg_wdata[EN_BIT];
   end

   p_enable_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_off == EN_OFFSET) |=> (win_en == $past(cfg_wdata[EN_BIT])));

   p_enable_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_off == EN_OFFSET) |=> $stable(win_en));

endmodule

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
   parameter int          ADDR_W      = 16,
   parameter int          DECODE_BITS = 16,
   parameter [ADDR_W-1:0] BASE_ADDR   = 16'h03F0
) (
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic              win_en,
   output logic              idx_we,
   output logic              dat_we,
   output logic              rd_claim
);

   if (DECODE_BITS < 2 || DECODE_BITS > ADDR_W) begin : g_bad_width
      $error("cfg_port_decode: DECODE_BITS out of range");
   end
   if (BASE_ADDR[0] != 1'b0) begin : g_bad_base
      $error("cfg_port_decode: BASE_ADDR must be even");
   end

   logic in_win;

   if (DECODE_BITS == ADDR_W) begin : g_full
      assign in_win = (io_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]);
   end else begin : g_partial
      // upper address bits are aliased away
      logic unused_hi;
      assign unused_hi = ^io_addr[ADDR_W-1:DECODE_BITS];
      assign in_win = (io_addr[DECODE_BITS-1:1] == BASE_ADDR[DECODE_BITS-1:1]);
   end

   assign idx_we   = win_en && io_wr && in_win && !io_addr[0];
   assign dat_we   = win_en && io_wr && in_win &&  io_addr[0];
   assign rd_claim = win_en && io_rd && in_win;

endmodule

// File: rtl/cfg_port_filter.sv
module cfg_port_filter
   import cfg_port_pkg::*;
(
   input  logic      dat_we,
   input  reg_idx_t  idx,
   input  reg_byte_t wdata,
   output logic      commit
);

   logic allowed;

   always_comb begin
      if (is_locked(idx))     allowed = 1'b0;
      else if (is_keyed(idx)) allowed = (wdata == key_value(idx));
      else                    allowed = 1'b1;
   end

   assign commit = dat_we && allowed;

endmodule

// File: rtl/cfg_port_array.sv
module cfg_port_array
   import cfg_port_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      we,
   input  reg_idx_t  waddr,
   input  reg_byte_t wdata,
   input  reg_idx_t  raddr,
   output reg_byte_t rdata
);

   reg_byte_t mem [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) mem[i] <= reg_default(IDX_W'(i));
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
   import cfg_port_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          DECODE_BITS = 16,
   parameter [ADDR_W-1:0] BASE_ADDR   = 16'h03F0,
   parameter [7:0]        EN_OFFSET   = 8'h85,
   parameter int          EN_BIT      = 1,
   parameter [7:0]        IDLE_READ   = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   output logic              io_hit,
   input  logic              brg_cfg_we,
   input  logic [7:0]        brg_cfg_off,
   input  logic [7:0]        brg_cfg_wdata
);

   if (REG_W != 8 || IDX_W != 8) begin : g_bad_pkg
      $error("cfg_index_port: byte-wide index and registers required");
   end

   localparam [ADDR_W-1:0] DATA_ADDR = BASE_ADDR | ADDR_W'(1);

   logic      win_en, idx_we, dat_we, rd_claim, commit;
   reg_idx_t  idx_q;
   reg_byte_t arr_rdata;

   cfg_port_enable #(
      .OFF_W(8), .DAT_W(8), .EN_OFFSET(EN_OFFSET), .EN_BIT(EN_BIT)
   ) i_enable (
      .clk(clk), .rst_n(rst_n), .cfg_we(brg_cfg_we), .cfg_off(brg_cfg_off),
      .cfg_wdata(brg_cfg_wdata), .win_en(win_en)
   );

   cfg_port_decode #(
      .ADDR_W(ADDR_W), .DECODE_BITS(DECODE_BITS), .BASE_ADDR(BASE_ADDR)
   ) i_decode (
      .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .win_en(win_en),
      .idx_we(idx_we), .dat_we(dat_we), .rd_claim(rd_claim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= io_wdata;
   end

   cfg_port_filter i_filter (
      .dat_we(dat_we), .idx(idx_q), .wdata(io_wdata), .commit(commit)
   );

   cfg_port_array i_array (
      .clk(clk), .rst_n(rst_n), .we(commit), .waddr(idx_q), .wdata(io_wdata),
      .raddr(idx_q), .rdata(arr_rdata)
   );

   assign io_hit   = rd_claim;
   assign io_rdata = rd_claim ? arr_rdata : IDLE_READ;

   p_idx_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |=> (idx_q == $past(io_wdata)));

   p_idx_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |=> $stable(idx_q));

   p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |-> (!io_hit && io_rdata == IDLE_READ));

   p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == DATA_ADDR && is_locked(idx_q)) |=> $stable(arr_rdata));

   p_key_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == DATA_ADDR && is_keyed(idx_q) &&
       io_wdata != key_value(idx_q)) |=> $stable(arr_rdata));

   p_commit_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (arr_rdata == $past(io_wdata)));

endmodule

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_hit;
   logic        brg_cfg_we = 1'b0;
   logic [7:0]  brg_cfg_off = '0, brg_cfg_wdata = '0;

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_mem [256];
   logic [7:0] exp_idx;
   logic       exp_en;

   always #10 clk = ~clk;

   cfg_index_port i_cfg_index_port (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_hit(io_hit),
      .brg_cfg_we(brg_cfg_we), .brg_cfg_off(brg_cfg_off), .brg_cfg_wdata(brg_cfg_wdata)
   );

   function automatic logic [7:0] bench_default(input logic [7:0] i);
      if (i == 8'hE0) return 8'h3C;
      if (i == 8'hE2) return 8'h03;
      if (i == 8'hE3) return 8'hFC;
      if (i == 8'hE6) return 8'hDE;
      if (i == 8'hE7) return 8'hFE;
      if (i == 8'hE8) return 8'hBE;
      return 8'h00;
   endfunction

   // positive list of writable registers, with key bytes
   function automatic logic bench_accept(input logic [7:0] i, input logic [7:0] d);
      if (i == 8'hE7) return d == 8'hFE;
      if (i == 8'hE8) return d == 8'hBE;
      case (i)
         8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hEE, 8'hEF, 8'hF0,
         8'hF1, 8'hF2, 8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic io_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      if (exp_en && a == 16'h03F0) exp_idx = d;
      else if (exp_en && a == 16'h03F1 && bench_accept(exp_idx, d)) exp_mem[exp_idx] = d;
   endtask

   task automatic io_read(input logic [15:0] a, input string req);
      logic in_win;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #2;
      in_win = exp_en && (a == 16'h03F0 || a == 16'h03F1);
      chk(req, {io_hit, io_rdata}, in_win ? {1'b1, exp_mem[exp_idx]} : {1'b0, 8'hFF});
      io_rd = 1'b0;
   endtask

   task automatic brg_write(input logic [7:0] off, input logic [7:0] d);
      @(negedge clk);
      brg_cfg_off = off; brg_cfg_wdata = d; brg_cfg_we = 1'b1;
      @(negedge clk);
      brg_cfg_we = 1'b0;
      if (off == 8'h85) exp_en = d[1];
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] ro_list [12];
      logic [7:0] rw_list [14];
      void'($urandom(32'h5EED_0042));
      for (int i = 0; i < 256; i++) exp_mem[i] = bench_default(8'(i));
      exp_idx = 8'h00; exp_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 / R1: disabled after reset
      io_read(16'h03F1, "R3 disabled read");
      io_read(16'h03F0, "R1 window off at reset");
      io_write(16'h03F0, 8'hE0);
      io_write(16'h03F1, 8'h55);
      // R2: other offsets and clear bit do not enable
      brg_write(8'h84, 8'hFF);
      io_read(16'h03F1, "R2 wrong offset");
      brg_write(8'h85, 8'hFD);
      io_read(16'h03F1, "R2 bit1 clear");
      brg_write(8'h85, 8'h02);
      // R1 / R3: index still 0, register 0 reads 00
      io_read(16'h03F1, "R1 index reset and R3 write ignored");
      // R1: defaults
      foreach (exp_mem[k]) begin
         if (k >= 8'hDC) begin
            io_write(16'h03F0, 8'(k));
            io_read(16'h03F1, "R1 default");
         end
      end
      // R4: index load, read at even address too
      io_write(16'h03F0, 8'hE6);
      io_read(16'h03F0, "R4 index then read even");
      io_read(16'h03F3, "R5 outside window");
      io_read(16'h13F1, "R5 upper bits differ");
      // R6: locked registers
      ro_list = '{8'h00, 8'h5A, 8'hDF, 8'hE4, 8'hE5, 8'hE9, 8'hED, 8'hF3, 8'hF5, 8'hF7, 8'hFA, 8'hFF};
      foreach (ro_list[k]) begin
         io_write(16'h03F0, ro_list[k]);
         io_write(16'h03F1, 8'hA5);
         io_read(16'h03F1, "R6 locked");
      end
      // R7: keyed registers
      io_write(16'h03F0, 8'hE7);
      io_write(16'h03F1, 8'h00);
      io_read(16'h03F1, "R7 E7 reject");
      io_write(16'h03F1, 8'hFE);
      io_read(16'h03F1, "R7 E7 key");
      io_write(16'h03F0, 8'hE8);
      io_write(16'h03F1, 8'hBF);
      io_read(16'h03F1, "R7 E8 reject");
      io_write(16'h03F1, 8'hBE);
      io_read(16'h03F1, "R7 E8 key");
      // R8: free registers
      rw_list = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6, 8'hF8, 8'hFC};
      foreach (rw_list[k]) begin
         io_write(16'h03F0, rw_list[k]);
         io_write(16'h03F1, rw_list[k] ^ 8'h69);
         io_read(16'h03F1, "R8 writable");
      end
      // R3: disable, writes are ignored, re-enable and check
      brg_write(8'h85, 8'h00);
      io_write(16'h03F0, 8'hE1);
      io_write(16'h03F1, 8'h12);
      io_read(16'h03F0, "R3 read while off");
      brg_write(8'h85, 8'h02);
      io_read(16'h03F1, "R3 state untouched");

      // constrained random mix
      for (int n = 0; n < 800; n++) begin
         int unsigned op;
         logic [7:0] r;
         op = $urandom % 16;
         r = 8'($urandom);
         if (op == 0) begin
            brg_write(($urandom % 2) ? 8'h85 : r, 8'($urandom) | 8'h02 & {8{($urandom % 4) != 0}});
         end else if (op <= 5) begin
            io_write(16'h03F0, ($urandom % 2) ? r : (8'hE0 | {3'b000, r[4:0]}));
         end else if (op <= 10) begin
            io_write(16'h03F1, (op == 6) ? 8'hFE : (op == 7) ? 8'hBE : r);
         end else begin
            io_read((op == 15) ? {8'h00, r} : ((op % 2) ? 16'h03F1 : 16'h03F0), "R5 random readback");
         end
      end
      finish_run();
   end

endmodule